// File: doc/BRIEF.md
# Per-Channel Frame Error Monitor

This block watches the decoded packet stream of a camera-serial receive path and tracks frame boundaries separately for each virtual channel. Each packet event arrives as a single-cycle valid strobe. The strobe carries a channel number and marks the packet as a frame start, a frame end, or a completed long payload, together with a flag saying whether that payload failed its CRC check. From these events the monitor decides, per channel, whether a frame end had no matching frame start, and whether a frame that closed cleanly still carried corrupted payload.

Three global conditions are recorded next to the per-channel flags: any payload CRC failure, any packet with an unsupported data identifier, and a lane setup in which the active lane count exceeds the configured maximum. All flags are sticky. They sit in one write-one-to-clear status word, and an interrupt line reports whether any flag that is enabled by a mask is set.

Status word layout, which the bench relies on: for channel v, bit 2v is the frame data error and bit 2v+1 is the frame sync error. The bit just above the channel pairs is the CRC error. The next bit up is the unsupported-type error, and the bit above that is the lane setup error. With four channels these three are bits 8, 9 and 10.

Top module: `vc_frame_err_mon`

## Requirements
- R1: After synchronous reset, every status bit and the interrupt output are 0.
- R2: A frame end on channel v that has no open frame on v sets status bit 2v+1, and this happens on the clock edge that accepts the event. A frame opened on another channel does not count as a match.
- R3: A frame end on channel v with an open frame sets bit 2v only if a payload with a CRC failure arrived on v after that frame started. A clean frame sets no bit. A frame end always closes the frame.
- R4: A frame start on a channel that already has an open frame restarts the frame and raises no flag. CRC failures seen before the restart no longer count.
- R5: Any completed payload with a CRC failure sets the global CRC bit (bit 2N, which is bit 8 for four channels), whether or not a frame is open.
- R6: A valid packet marked as carrying an unsupported data identifier sets the unsupported-type bit (bit 9 for four channels).
- R7: While the active lane count is strictly greater than the maximum lane count, the lane setup bit (bit 10 for four channels) is set. Equal counts set nothing.
- R8: A register write clears every status bit whose write-data bit is 1 and leaves bits written 0 unchanged. Without a write or a set event, the status holds its value.
- R9: When a set event and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R10: The interrupt output is registered. One cycle after the status changes, it equals the OR over all status bits ANDed with the enable mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pkt_vld | input | 1 | Packet event strobe |
| pkt_vc | input | VC_W | Virtual channel of the event |
| pkt_fs | input | 1 | Event is a frame start |
| pkt_fe | input | 1 | Event is a frame end |
| pkt_payload_done | input | 1 | Event closes a long payload |
| pkt_crc_bad | input | 1 | Payload CRC mismatch |
| pkt_dt_bad | input | 1 | Data identifier unsupported |
| lanes_active | input | LANE_W | Active lane count |
| lanes_max | input | LANE_W | Configured maximum lane count |
| reg_wr | input | 1 | Status write strobe (write one to clear) |
| reg_wdata | input | STAT_W | Status write data |
| irq_mask | input | STAT_W | Per-bit interrupt enable |
| status | output | STAT_W | Sticky status word |
| irq | output | 1 | Registered interrupt |

## Verification
The bench builds the block with its defaults: four channels and 3-bit lane counts. With four channels, every data and sync bit pair can be reached, and a frame end on one channel can be tested against an open frame on another. With 3-bit lane counts, the bench can drive counts above, equal to and below the maximum, so the strict-greater boundary gets tested. A walked table covers the restart, the CRC ordering and the set-beats-clear sequences. Directed steps then cover the lane boundary, the mask and its one-cycle delay, and a reset from a nonzero state.

// File: rtl/frame_mon_pkg.sv
package frame_mon_pkg;

  // Kind of packet event seen on the decoded stream
  typedef struct packed {
    logic fs;
    logic fe;
    logic pd;
    logic crc;
  } pkt_kind_t;

  function automatic int data_bit(input int vc);
    return 2 * vc;
  endfunction

  function automatic int sync_bit(input int vc);
    return 2 * vc + 1;
  endfunction

endpackage

// File: rtl/vc_frame_tracker.sv
module vc_frame_tracker
  import frame_mon_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      hit,
  input  pkt_kind_t kind,
  output logic      sync_set,
  output logic      data_set
);

  logic in_frame;
  logic crc_seen;
  logic fe_ev, fs_ev, bad_ev;

  // A frame end takes priority; payload only counts on a plain payload event
  assign fe_ev  = hit & kind.fe;
  assign fs_ev  = hit & kind.fs & ~kind.fe;
  assign bad_ev = hit & kind.pd & kind.crc & ~kind.fs & ~kind.fe;

  assign sync_set = fe_ev & ~in_frame;
  assign data_set = fe_ev & in_frame & crc_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      crc_seen <= 1'b0;
    end else if (fe_ev) begin
      in_frame <= 1'b0;
      crc_seen <= 1'b0;
    end else if (fs_ev) begin
      in_frame <= 1'b1;
      crc_seen <= 1'b0;
    end else if (bad_ev && in_frame) begin
      crc_seen <= 1'b1;
    end
  end

  AST_FE_CLOSES: assert property (@(posedge clk) disable iff (rst)
    fe_ev |=> !in_frame && !crc_seen); // R3
  AST_FS_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    fs_ev |=> in_frame && !crc_seen); // R4
  AST_SEEN_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
    crc_seen |-> in_frame); // R3

endmodule

// File: rtl/w1c_status_reg.sv
module w1c_status_reg #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status
);

  logic [W-1:0] clr_vec;

  assign clr_vec = wr ? wdata : '0;

  // Set after clear, so a same-cycle event survives the write
  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~clr_vec) | set_vec;
  end

  AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (rst)
    (wr && set_vec == '0) |=> ((status & $past(wdata)) == '0)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!wr && set_vec == '0) |=> (status == $past(status))); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec))); // R9

endmodule

// File: rtl/irq_gen.sv
module irq_gen #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] status,
  input  logic [W-1:0] mask,
  output logic         irq
);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status & mask);
  end

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |($past(status) & $past(mask)))); // R10

endmodule

// File: rtl/vc_frame_err_mon.sv
module vc_frame_err_mon
  import frame_mon_pkg::*;
#(
  parameter int NUM_VC = 4,
  parameter int LANE_W = 3,
  parameter int VC_W   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  parameter int STAT_W = 2 * NUM_VC + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_vld,
  input  logic [VC_W-1:0]   pkt_vc,
  input  logic              pkt_fs,
  input  logic              pkt_fe,
  input  logic              pkt_payload_done,
  input  logic              pkt_crc_bad,
  input  logic              pkt_dt_bad,
  input  logic [LANE_W-1:0] lanes_active,
  input  logic [LANE_W-1:0] lanes_max,
  input  logic              reg_wr,
  input  logic [STAT_W-1:0] reg_wdata,
  input  logic [STAT_W-1:0] irq_mask,
  output logic [STAT_W-1:0] status,
  output logic              irq
);

  localparam int CRC_BIT  = 2 * NUM_VC;
  localparam int DT_BIT   = CRC_BIT + 1;
  localparam int LANE_BIT = CRC_BIT + 2;

  pkt_kind_t         kind;
  logic [NUM_VC-1:0] sync_set;
  logic [NUM_VC-1:0] data_set;
  logic [STAT_W-1:0] set_vec;
  logic              crc_ev, dt_ev, lane_bad;

  assign kind.fs  = pkt_fs;
  assign kind.fe  = pkt_fe;
  assign kind.pd  = pkt_payload_done;
  assign kind.crc = pkt_crc_bad;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    vc_frame_tracker u_trk (
      .clk      (clk),
      .rst      (rst),
      .hit      (pkt_vld && (pkt_vc == VC_W'(v))),
      .kind     (kind),
      .sync_set (sync_set[v]),
      .data_set (data_set[v])
    );
  end

  assign crc_ev   = pkt_vld & pkt_payload_done & pkt_crc_bad & ~pkt_fs & ~pkt_fe;
  assign dt_ev    = pkt_vld & pkt_dt_bad;
  assign lane_bad = lanes_active > lanes_max;

  always_comb begin
    set_vec = '0;
    for (int v = 0; v < NUM_VC; v++) begin
      set_vec[sync_bit(v)] = sync_set[v];
      set_vec[data_bit(v)] = data_set[v];
    end
    set_vec[CRC_BIT]  = crc_ev;
    set_vec[DT_BIT]   = dt_ev;
    set_vec[LANE_BIT] = lane_bad;
  end

  w1c_status_reg #(.W(STAT_W)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .wr      (reg_wr),
    .wdata   (reg_wdata),
    .status  (status)
  );

  irq_gen #(.W(STAT_W)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .status (status),
    .mask   (irq_mask),
    .irq    (irq)
  );

  AST_LANE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (lanes_active > lanes_max) |=> status[LANE_BIT]); // R7
  AST_DT_FLAG: assert property (@(posedge clk) disable iff (rst)
    (pkt_vld && pkt_dt_bad) |=> status[DT_BIT]); // R6
  AST_CRC_FLAG: assert property (@(posedge clk) disable iff (rst)
    (pkt_vld && pkt_payload_done && pkt_crc_bad && !pkt_fs && !pkt_fe) |=> status[CRC_BIT]); // R5

endmodule

// File: tb/sim_vc_frame_err_mon.sv
module sim_vc_frame_err_mon;

  localparam int NUM_VC = 4;
  localparam int LANE_W = 3;
  localparam int VC_W   = 2;
  localparam int STAT_W = 11;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              pkt_vld = 1'b0;
  logic [VC_W-1:0]   pkt_vc = '0;
  logic              pkt_fs = 1'b0, pkt_fe = 1'b0, pkt_payload_done = 1'b0;
  logic              pkt_crc_bad = 1'b0, pkt_dt_bad = 1'b0;
  logic [LANE_W-1:0] lanes_active = 3'd2, lanes_max = 3'd4;
  logic              reg_wr = 1'b0;
  logic [STAT_W-1:0] reg_wdata = '0, irq_mask = '0;
  logic [STAT_W-1:0] status;
  logic              irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  vc_frame_err_mon #(.NUM_VC(NUM_VC), .LANE_W(LANE_W)) u0 (
    .clk(clk), .rst(rst), .pkt_vld(pkt_vld), .pkt_vc(pkt_vc),
    .pkt_fs(pkt_fs), .pkt_fe(pkt_fe), .pkt_payload_done(pkt_payload_done),
    .pkt_crc_bad(pkt_crc_bad), .pkt_dt_bad(pkt_dt_bad),
    .lanes_active(lanes_active), .lanes_max(lanes_max),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .irq_mask(irq_mask),
    .status(status), .irq(irq)
  );

  // Row: {pad, vld, vc[2], fs, fe, pd, crc, dt, wr, wdata[11], expected status[11]}
  localparam int NV = 26;
  localparam logic [31:0] VEC [NV] = '{
    {1'b0,1'b1,2'd3,4'b0100,1'b0,1'b0,11'h000,11'h080}, // R2 lone FE vc3
    {1'b0,1'b1,2'd2,4'b1000,1'b0,1'b0,11'h000,11'h080}, // FS vc2
    {1'b0,1'b1,2'd2,4'b0011,1'b0,1'b0,11'h000,11'h180}, // R5 bad payload
    {1'b0,1'b1,2'd2,4'b0100,1'b0,1'b0,11'h000,11'h190}, // R3 data error vc2
    {1'b0,1'b0,2'd0,4'b0000,1'b0,1'b1,11'h190,11'h000}, // R8 clear
    {1'b0,1'b1,2'd1,4'b1000,1'b0,1'b0,11'h000,11'h000}, // FS vc1
    {1'b0,1'b1,2'd1,4'b0010,1'b0,1'b0,11'h000,11'h000}, // R3 good payload
    {1'b0,1'b1,2'd1,4'b0100,1'b0,1'b0,11'h000,11'h000}, // R3 clean frame
    {1'b0,1'b1,2'd0,4'b1000,1'b0,1'b0,11'h000,11'h000}, // FS vc0
    {1'b0,1'b1,2'd0,4'b1000,1'b0,1'b0,11'h000,11'h000}, // R4 repeat FS
    {1'b0,1'b1,2'd0,4'b0011,1'b0,1'b0,11'h000,11'h100}, // R5
    {1'b0,1'b1,2'd0,4'b1000,1'b0,1'b0,11'h000,11'h100}, // R4 restart
    {1'b0,1'b1,2'd0,4'b0100,1'b0,1'b0,11'h000,11'h100}, // R4 no data error
    {1'b0,1'b1,2'd0,4'b0100,1'b0,1'b0,11'h000,11'h102}, // R2 second FE
    {1'b0,1'b1,2'd3,4'b0011,1'b0,1'b0,11'h000,11'h102}, // R5 outside frame
    {1'b0,1'b1,2'd3,4'b1000,1'b0,1'b0,11'h000,11'h102}, // FS vc3
    {1'b0,1'b1,2'd3,4'b0100,1'b0,1'b0,11'h000,11'h102}, // R3 early CRC ignored
    {1'b0,1'b1,2'd1,4'b0000,1'b1,1'b0,11'h000,11'h302}, // R6
    {1'b0,1'b0,2'd0,4'b0000,1'b0,1'b1,11'h000,11'h302}, // R8 write zero
    {1'b0,1'b1,2'd1,4'b0011,1'b0,1'b1,11'h100,11'h302}, // R9 set beats clear
    {1'b0,1'b0,2'd0,4'b0000,1'b0,1'b1,11'h7FF,11'h000}, // R8 clear all
    {1'b0,1'b1,2'd1,4'b1000,1'b0,1'b0,11'h000,11'h000}, // FS vc1
    {1'b0,1'b1,2'd1,4'b0011,1'b0,1'b0,11'h000,11'h100}, // R5
    {1'b0,1'b1,2'd2,4'b0100,1'b0,1'b0,11'h000,11'h120}, // R2 other channel
    {1'b0,1'b1,2'd1,4'b0100,1'b0,1'b0,11'h000,11'h124}, // R3 data error vc1
    {1'b0,1'b0,2'd0,4'b0000,1'b0,1'b1,11'h7FF,11'h000}  // R8
  };
  localparam int VREQ [NV] = '{2,3,5,3,8,3,3,3,3,4,5,4,4,2,5,3,3,6,8,9,8,3,5,2,3,8};

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    pkt_vld = 0; pkt_fs = 0; pkt_fe = 0; pkt_payload_done = 0;
    pkt_crc_bad = 0; pkt_dt_bad = 0; reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(1, 32'(status), 0); // R1
    chk(1, 32'(irq), 0);    // R1
    @(negedge clk) rst = 0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pkt_vld = VEC[i][30]; pkt_vc = VEC[i][29:28];
      pkt_fs = VEC[i][27]; pkt_fe = VEC[i][26];
      pkt_payload_done = VEC[i][25]; pkt_crc_bad = VEC[i][24];
      pkt_dt_bad = VEC[i][23]; reg_wr = VEC[i][22]; reg_wdata = VEC[i][21:11];
      step();
      chk(VREQ[i], 32'(status), 32'(VEC[i][10:0]));
    end
    @(negedge clk) idle();

    // R7 boundary: equal counts raise nothing
    lanes_active = 3'd3; lanes_max = 3'd3;
    step(); chk(7, 32'(status), 0);
    @(negedge clk) lanes_active = 3'd4;
    step(); chk(7, 32'(status), 32'h400);
    @(negedge clk) begin reg_wr = 1; reg_wdata = 11'h400; end
    step(); chk(9, 32'(status), 32'h400); // R9 persistent condition wins
    @(negedge clk) lanes_active = 3'd1;
    step(); chk(8, 32'(status), 0);
    @(negedge clk) idle();

    // R10 masking and one-cycle delay
    @(negedge clk) begin pkt_vld = 1; pkt_dt_bad = 1; end
    @(negedge clk) idle();
    step(); chk(10, 32'(irq), 0); // masked off
    @(negedge clk) irq_mask = 11'h200;
    step(); chk(10, 32'(irq), 1);
    @(negedge clk) begin reg_wr = 1; reg_wdata = 11'h200; end
    step(); chk(10, 32'(irq), 1); // still reflects previous status
    @(negedge clk) idle();
    step(); chk(10, 32'(irq), 0);

    // R1 reset from a nonzero state
    @(negedge clk) begin pkt_vld = 1; pkt_vc = 2'd0; pkt_fe = 1; end
    @(negedge clk) idle();
    chk(2, 32'(status), 32'h002);
    @(negedge clk) rst = 1;
    step(); chk(1, 32'(status), 0);
    step(); chk(1, 32'(irq), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule